// File: doc/BRIEF.md
# E1 Sa6 Code Detector

This block watches the Sa6 spare bit that arrives from each E1 frame carrying spare bits. It packs those bits into 4-bit nibbles. The first bit received becomes the most significant bit and the fourth becomes the least significant. The block then looks for a fixed set of nibble codes.

A code counts as present only after the same nibble pattern has arrived in three consecutive nibble slots. The held code stays in place until a different pattern has itself repeated three times. It is then replaced.

There are two independent detection paths:

- **General path.** It recognises the codes 8h, Ah, Ch, Eh and Fh. Every other pattern is classed as X. Its nibble boundary either runs freely from the moment basic frame alignment is gained, or is tied to the CRC-4 submultiframe boundary when synchronous framing is forced in CRC-4 mode. Synchronous framing also requires multiframe alignment.
- **Event path.** It recognises 1h, 2h and 3h, which report remote-terminal events. It is always framed on the submultiframe boundary and runs only in CRC-4 mode with multiframe alignment. It produces one count pulse per qualifying nibble, which external counters consume.

General codes land in a sticky status register. Several bits may pile up there, and a read leaves only the bit of the code currently held. A maskable interrupt pulse accompanies each newly held code.

Top module: `sa6_code_detector`

## Requirements
- R1: Nibbles are built first-bit-as-MSB. The general classes map to status bits 8h→bit0, Ah→bit1, Ch→bit2, Eh→bit3, Fh→bit4, and any other pattern (X)→bit5.
- R2: A code becomes held, and its status bit is set, only on the third consecutive nibble with the same 4-bit pattern. Two repeats, or three different X patterns, set nothing.
- R3: A held code is replaced only when a different pattern has arrived in three consecutive nibbles. Fewer repeats leave the held code unchanged.
- R4: In free-running mode, the nibble boundary is every fourth Sa6 bit counted from the cycle in which alignment is gained. Bits received while unaligned are discarded.
- R5: Free-running general detection requires `frm_aligned`. With `crc4_mode` and `sync_sel` both set, general nibbles start at a bit flagged by `smf_bnd` and require `mf_aligned`.
- R6: Event codes 1h, 2h and 3h drive `nt1_evt[0]`, `nt1_evt[1]` and `nt1_evt[2]` respectively. Each pulse lasts one clock and fires for every nibble from the third identical one onward. Pulses occur only with `crc4_mode` and `mf_aligned`, on submultiframe framing.
- R7: Status bits are sticky and may be set together. A `stat_rd` pulse leaves only the bit of the currently held general code, or no bit if none is held.
- R8: Losing the required alignment clears the nibble shifter, the repeat count and the held code, but not the status bits.
- R9: `irq` pulses for one clock when a new general code becomes held and its `int_mask` bit is set. A code that keeps repeating, or a masked code, gives no pulse.
- R10: After reset, `stat_q`, `irq` and `nt1_evt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sa6_vld | input | 1 | Strobe: an Sa6 bit is present this cycle |
| sa6_bit | input | 1 | Sa6 bit value |
| smf_bnd | input | 1 | With `sa6_vld`: this bit opens a submultiframe |
| frm_aligned | input | 1 | Basic frame alignment held |
| mf_aligned | input | 1 | CRC-4 multiframe alignment held |
| crc4_mode | input | 1 | CRC-4 operation selected |
| sync_sel | input | 1 | Force general codes onto submultiframe framing |
| int_mask | input | 6 | Per-status-bit interrupt enable |
| stat_rd | input | 1 | Status read strobe (clear-on-read) |
| stat_q | output | 6 | Sticky general-code status |
| irq | output | 1 | Interrupt pulse for a newly held, unmasked code |
| nt1_evt | output | 3 | Event-count pulses for 1h, 2h, 3h |

## Verification
The in-line assertions check, on every cycle, the rules that hold at all times:

- nibbles only follow enabled bit strobes;
- a held code only appears, or changes, directly after a nibble of that value;
- event pulses only occur while the event path is enabled;
- the status register is one-hot or empty after every read;
- an interrupt is always followed by a set status bit.

Only the bench's scenarios can show the rest:

- the exact code-to-bit mapping and MSB-first packing;
- that two repeats or mixed X patterns fail to qualify;
- where free-running framing starts;
- that status survives loss of alignment;
- that repeated or masked codes stay silent on `irq`.

// File: rtl/sa6_pkg.sv
package sa6_pkg;
   localparam int unsigned NCODE = 6;
   localparam int unsigned CLS_W = 3;

   // general-path class index; X collects every unlisted pattern
   function automatic logic [CLS_W-1:0] gen_class(input logic [3:0] nib);
      case (nib)
         4'h8:    gen_class = 3'd0;
         4'hA:    gen_class = 3'd1;
         4'hC:    gen_class = 3'd2;
         4'hE:    gen_class = 3'd3;
         4'hF:    gen_class = 3'd4;
         default: gen_class = 3'd5;
      endcase
   endfunction
endpackage

// File: rtl/sa6_nib_track.sv
module sa6_nib_track #(
   parameter int unsigned NIB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             sync_in,
   input  logic             bit_vld,
   input  logic             bit_in,
   input  logic             bnd,
   output logic             nib_vld,
   output logic [NIB_W-1:0] nib
);
   localparam int unsigned PW = $clog2(NIB_W);
   localparam logic [PW-1:0] LAST = PW'(NIB_W - 1);

   logic [PW-1:0]    pos;
   logic [NIB_W-2:0] sh;
   logic             armed;

   if (NIB_W < 3) begin : g_bad_w
      $error("sa6_nib_track: NIB_W must be at least 3");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos     <= '0;
         sh      <= '0;
         armed   <= 1'b0;
         nib_vld <= 1'b0;
         nib     <= '0;
      end else begin
         nib_vld <= 1'b0;
         if (!en) begin
            pos   <= '0;
            sh    <= '0;
            armed <= 1'b0;
         end else if (bit_vld) begin
            if (sync_in && bnd) begin
               sh    <= {{(NIB_W-2){1'b0}}, bit_in};
               pos   <= PW'(1);
               armed <= 1'b1;
            end else if (!sync_in || armed) begin
               if (pos == LAST) begin
                  nib     <= {sh, bit_in};
                  nib_vld <= 1'b1;
                  pos     <= '0;
               end else begin
                  sh  <= {sh[NIB_W-3:0], bit_in};
                  pos <= pos + PW'(1);
               end
            end
         end
      end
   end

   // R4
   nib_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nib_vld |-> ($past(bit_vld) && $past(en)));
endmodule

// File: rtl/sa6_persist.sv
module sa6_persist #(
   parameter int unsigned W      = 4,
   parameter int unsigned REPEAT = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         code_vld,
   input  logic [W-1:0] code,
   output logic [W-1:0] held,
   output logic         held_vld,
   output logic         adopt,
   output logic         hit
);
   localparam int unsigned CW = $clog2(REPEAT + 1);
   localparam logic [CW-1:0] TOP = CW'(REPEAT);

   logic [W-1:0]  cand;
   logic [CW-1:0] cnt, nxt_cnt;

   if (REPEAT < 2) begin : g_bad_rep
      $error("sa6_persist: REPEAT must be at least 2");
   end

   always_comb begin
      if (code == cand && cnt != '0)
         nxt_cnt = (cnt == TOP) ? cnt : cnt + CW'(1);
      else
         nxt_cnt = CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand <= '0; cnt <= '0; held <= '0; held_vld <= 1'b0;
         adopt <= 1'b0; hit <= 1'b0;
      end else if (!en) begin
         cand <= '0; cnt <= '0; held <= '0; held_vld <= 1'b0;
         adopt <= 1'b0; hit <= 1'b0;
      end else begin
         adopt <= 1'b0;
         hit   <= 1'b0;
         if (code_vld) begin
            cand <= code;
            cnt  <= nxt_cnt;
            if (nxt_cnt == TOP) begin
               hit <= 1'b1;
               if (!held_vld || held != code) begin
                  held     <= code;
                  held_vld <= 1'b1;
                  adopt    <= 1'b1;
               end
            end
         end
      end
   end

   // R2
   hold_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(held_vld) |-> ($past(code_vld) && $past(code) == held));
   // R3
   held_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held_vld && $past(held_vld) && held != $past(held)) |-> ($past(code_vld) && $past(code) == held));
endmodule

// File: rtl/sa6_code_detector.sv
module sa6_code_detector
   import sa6_pkg::*;
#(
   parameter int unsigned NIB_W  = 4,
   parameter int unsigned REPEAT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sa6_vld,
   input  logic             sa6_bit,
   input  logic             smf_bnd,
   input  logic             frm_aligned,
   input  logic             mf_aligned,
   input  logic             crc4_mode,
   input  logic             sync_sel,
   input  logic [NCODE-1:0] int_mask,
   input  logic             stat_rd,
   output logic [NCODE-1:0] stat_q,
   output logic             irq,
   output logic [2:0]       nt1_evt
);
   if (NIB_W != 4) begin : g_bad_nib
      $error("sa6_code_detector: code tables need NIB_W == 4");
   end

   logic gen_sync, en_gen, en_nt1;
   assign gen_sync = crc4_mode & sync_sel;
   assign en_gen   = gen_sync ? mf_aligned : frm_aligned;
   assign en_nt1   = crc4_mode & mf_aligned;

   logic             nv_g, nv_n;
   logic [NIB_W-1:0] nib_g, nib_n;

   sa6_nib_track #(.NIB_W(NIB_W)) u_trk_gen (
      .clk(clk), .rst_n(rst_n), .en(en_gen), .sync_in(gen_sync),
      .bit_vld(sa6_vld), .bit_in(sa6_bit), .bnd(smf_bnd),
      .nib_vld(nv_g), .nib(nib_g));

   sa6_nib_track #(.NIB_W(NIB_W)) u_trk_nt1 (
      .clk(clk), .rst_n(rst_n), .en(en_nt1), .sync_in(1'b1),
      .bit_vld(sa6_vld), .bit_in(sa6_bit), .bnd(smf_bnd),
      .nib_vld(nv_n), .nib(nib_n));

   logic [NIB_W-1:0] held_g, held_n;
   logic             hv_g, hv_n, adopt_g, adopt_n, hit_g, hit_n;

   sa6_persist #(.W(NIB_W), .REPEAT(REPEAT)) u_per_gen (
      .clk(clk), .rst_n(rst_n), .en(en_gen), .code_vld(nv_g), .code(nib_g),
      .held(held_g), .held_vld(hv_g), .adopt(adopt_g), .hit(hit_g));

   sa6_persist #(.W(NIB_W), .REPEAT(REPEAT)) u_per_nt1 (
      .clk(clk), .rst_n(rst_n), .en(en_nt1), .code_vld(nv_n), .code(nib_n),
      .held(held_n), .held_vld(hv_n), .adopt(adopt_n), .hit(hit_n));

   logic [CLS_W-1:0] cls_g;
   logic [NCODE-1:0] set_vec, keep_vec;
   assign cls_g = gen_class(held_g);

   for (genvar i = 0; i < NCODE; i++) begin : g_stat
      assign set_vec[i]  = adopt_g && (cls_g == CLS_W'(i));
      assign keep_vec[i] = hv_g && (cls_g == CLS_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       stat_q[i] <= 1'b0;
         else if (stat_rd) stat_q[i] <= keep_vec[i] | set_vec[i];
         else              stat_q[i] <= stat_q[i] | set_vec[i];
      end
   end

   assign irq = |(set_vec & int_mask);

   for (genvar k = 0; k < 3; k++) begin : g_evt
      assign nt1_evt[k] = hit_n && (held_n == NIB_W'(k + 1));
   end

   // R5
   gen_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adopt_g |-> ($past(en_gen) && hit_g));
   // R6
   nt1_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nt1_evt != 3'b000) |-> ($past(en_nt1) && hv_n));
   // R6
   nt1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adopt_n |-> hit_n);
   // R7
   rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stat_rd) |-> $onehot0(stat_q));
   // R9
   irq_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> (stat_q != '0));
endmodule

// File: tb/sa6_code_detector_tb.sv
`timescale 1ns/1ps
module sa6_code_detector_tb;
   logic       clk = 1'b0, rst_n = 1'b0;
   logic       sa6_vld = 0, sa6_bit = 0, smf_bnd = 0;
   logic       frm_aligned = 0, mf_aligned = 0, crc4_mode = 0, sync_sel = 0;
   logic [5:0] int_mask = 6'h3F;
   logic       stat_rd = 0;
   logic [5:0] stat_q;
   logic       irq;
   logic [2:0] nt1_evt;

   int errors = 0, checks = 0;
   int irq_cnt = 0;
   int ecnt [3] = '{0, 0, 0};
   bit done = 0;

   always #2.5 clk = ~clk;

   sa6_code_detector u_dut (
      .clk(clk), .rst_n(rst_n), .sa6_vld(sa6_vld), .sa6_bit(sa6_bit),
      .smf_bnd(smf_bnd), .frm_aligned(frm_aligned), .mf_aligned(mf_aligned),
      .crc4_mode(crc4_mode), .sync_sel(sync_sel), .int_mask(int_mask),
      .stat_rd(stat_rd), .stat_q(stat_q), .irq(irq), .nt1_evt(nt1_evt));

   always @(posedge clk) begin
      if (irq) irq_cnt <= irq_cnt + 1;
      for (int k = 0; k < 3; k++) if (nt1_evt[k]) ecnt[k] <= ecnt[k] + 1;
   end

   // nibble A, B, C then expected status after them (free-running mode)
   localparam logic [17:0] VEC [9] = '{
      {4'h8, 4'h8, 4'h8, 6'b000001},   // R1 8h
      {4'hA, 4'hA, 4'hA, 6'b000010},   // R1 Ah
      {4'hC, 4'hC, 4'hC, 6'b000100},   // R1 Ch
      {4'hE, 4'hE, 4'hE, 6'b001000},   // R1 Eh
      {4'hF, 4'hF, 4'hF, 6'b010000},   // R1 Fh
      {4'h5, 4'h5, 4'h5, 6'b100000},   // R1 X
      {4'hA, 4'hA, 4'hC, 6'b000000},   // R2 broken run
      {4'h9, 4'hB, 4'hD, 6'b000000},   // R2 mixed X
      {4'h7, 4'h7, 4'h7, 6'b100000}    // R1 X
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic put_bit(input logic b, input logic first);
      @(negedge clk); sa6_vld = 1; sa6_bit = b; smf_bnd = first;
      @(negedge clk); sa6_vld = 0; smf_bnd = 0;
   endtask

   task automatic put_nib(input logic [3:0] n, input logic with_bnd);
      for (int i = 3; i >= 0; i--) put_bit(n[i], with_bnd && i == 3);
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic rd_stat();
      @(negedge clk); stat_rd = 1;
      @(negedge clk); stat_rd = 0;
   endtask

   task automatic realign();
      @(negedge clk); frm_aligned = 0; mf_aligned = 0;
      repeat (2) @(negedge clk);
      frm_aligned = 1; mf_aligned = 1;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int i0, e0;
      repeat (3) @(negedge clk);
      chk("R10 stat", stat_q, 0);
      chk("R10 irq", irq, 0);
      chk("R10 evt", nt1_evt, 0);
      rst_n = 1;

      // table walk, free-running framing, all interrupts enabled
      foreach (VEC[v]) begin
         realign(); rd_stat();
         i0 = irq_cnt;
         put_nib(VEC[v][17:14], 0); put_nib(VEC[v][13:10], 0); put_nib(VEC[v][9:6], 0);
         settle();
         chk("R1/R2 stat", stat_q, VEC[v][5:0]);
         chk("R9 irq count", irq_cnt - i0, (VEC[v][5:0] != 0) ? 1 : 0);
      end

      // R4: bits before alignment gain are dropped; framing starts at gain
      @(negedge clk); frm_aligned = 0; mf_aligned = 0;
      rd_stat();
      put_bit(1, 0); put_bit(1, 0);
      frm_aligned = 1;
      repeat (3) put_nib(4'h8, 0);
      settle();
      chk("R4 framing from gain", stat_q, 6'b000001);

      // R7: several bits pile up, read keeps only the held one
      realign(); rd_stat();
      repeat (3) put_nib(4'h8, 0);
      repeat (3) put_nib(4'hA, 0);
      settle();
      chk("R7 multi before read", stat_q, 6'b000011);
      rd_stat();
      chk("R7 after read", stat_q, 6'b000010);

      // R3: two C nibbles keep A held; the third replaces it
      put_nib(4'hC, 0); put_nib(4'hC, 0); settle(); rd_stat();
      chk("R3 held kept", stat_q, 6'b000010);
      put_nib(4'hC, 0); settle(); rd_stat();
      chk("R3 replaced", stat_q, 6'b000100);

      // R9: continued repeats and masked codes stay silent
      i0 = irq_cnt;
      put_nib(4'hC, 0); settle();
      chk("R9 repeat no irq", irq_cnt - i0, 0);
      int_mask = 6'b111101;
      repeat (3) put_nib(4'hA, 0); settle();
      chk("R9 masked no irq", irq_cnt - i0, 0);
      int_mask = 6'h3F;

      // R8: alignment loss keeps sticky bits but drops the held code
      @(negedge clk); frm_aligned = 0; mf_aligned = 0; settle();
      chk("R8 sticky kept", stat_q, 6'b000110);
      rd_stat();
      chk("R8 held cleared", stat_q, 6'b000000);

      // R5: forced submultiframe framing needs multiframe alignment
      crc4_mode = 1; sync_sel = 1; frm_aligned = 1; mf_aligned = 0;
      repeat (3) put_nib(4'hE, 1); settle();
      chk("R5 no mf align", stat_q, 6'b000000);
      mf_aligned = 1;
      put_bit(0, 0); put_bit(1, 0);
      repeat (3) put_nib(4'hE, 1); settle();
      chk("R5 sync framed", stat_q, 6'b001000);

      // R6: event pulses per qualifying nibble, CRC-4 only
      sync_sel = 0;
      e0 = ecnt[1]; i0 = ecnt[0] + ecnt[2];
      repeat (4) put_nib(4'h2, 1); settle();
      chk("R6 evt 2h pulses", ecnt[1] - e0, 2);
      chk("R6 other evts", ecnt[0] + ecnt[2] - i0, 0);
      crc4_mode = 0;
      e0 = ecnt[0];
      repeat (3) put_nib(4'h1, 1); settle();
      chk("R6 no crc4 no evt", ecnt[0] - e0, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule